// File: doc/BRIEF.md
# Packed-Word Dual-Side FIFO Buffer

This block buffers data between a byte-wide producer and a word-wide consumer. The producer side presents one byte per load. In packed mode two successive bytes are joined into one word, and storage is touched only once the second byte has arrived. In unpacked mode every byte becomes a word of its own, with the upper half zero. The consumer side takes one whole word per read strobe.

The words live in a single-port synchronous array made of narrow slices. A slot scheduler alternates write slots and read slots, one per clock. A pending write request or read request waits at most one cycle for its slot, so the array is never asked for two accesses in the same cycle.

Occupancy is kept as a word count, and the block raises flags for empty and full. Two sticky error flags record a word write attempted on a full buffer and a read attempted on an empty one. A synchronous initialize input discards the whole contents.

The producer spaces its byte loads at least two cycles apart. The consumer does the same with its strobes.

Top module: `pkfifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `overflow`=0, `underflow`=0, `word_count`=0 and `rd_valid`=0. `full` and `empty` are never high together.
- R2: With `pack_en`=1, the first byte of a pair is held and does not change `word_count`. The second byte completes the word {second byte in bits 15:8, first byte in bits 7:0}, and only then does the count rise by one.
- R3: With `pack_en`=0, each byte load creates one word with the byte in bits 7:0 and zeros in bits 15:8.
- R4: Words come out in the order they were completed. For each accepted strobe, `rd_valid` pulses for one cycle within four cycles, and `rd_word` carries the word in that cycle.
- R5: `full` rises when `word_count` reaches DEPTH. A word completed while the count plus any pending write equals DEPTH is dropped, and the stored contents and count stay as they were.
- R6: A strobe while `word_count`=0 produces no `rd_valid` pulse, leaves the count at 0 and sets `underflow` on the next cycle.
- R7: `overflow` and `underflow` stay set until `err_clr` or `init`. `err_clr` clears both, and a new error in the same cycle takes priority.
- R8: `init` empties the buffer and discards any held first byte. Later reads see only data written after it.
- R9: The array serves at most one access per cycle. Writes and reads interleaved in one stream still return every word intact and in order.
- R10: `word_count` changes by at most one per cycle, outside `init`, and equals the number of stored words not yet claimed by a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous clear of contents, pointers, held byte and flags |
| err_clr | input | 1 | Clears the sticky error flags |
| pack_en | input | 1 | 1 = two bytes per word, 0 = one byte per word |
| byte_vld | input | 1 | Byte load strobe |
| byte_in | input | BYTE_W | Byte to load |
| rd_strobe | input | 1 | Word read request |
| rd_word | output | 2*BYTE_W | Word returned by the last read |
| rd_valid | output | 1 | One-cycle pulse when `rd_word` is new |
| word_count | output | clog2(DEPTH+1) | Words held |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count equals DEPTH |
| overflow | output | 1 | Sticky: word completed while full |
| underflow | output | 1 | Sticky: strobe while empty |

## Verification
Several rules are checked by assertions on every cycle. These are the single-access rule of the array, the bound and single-step movement of the count, the exclusivity of `full` and `empty`, the stickiness of both error flags and the setting of `underflow` after a strobe on an empty buffer. Other behaviour can only be shown by the directed scenarios. That covers byte ordering within a packed word, zero extension in unpacked mode, first-in first-out order across a complete fill and drain, and the fact that a rejected word leaves the contents untouched. It also covers the discarding of a held byte by `init`.

// File: rtl/pkfifo_pkg.sv
package pkfifo_pkg;
   // Array slot ownership, alternating each clock.
   typedef enum logic {
      SLOT_WR = 1'b0,
      SLOT_RD = 1'b1
   } slot_e;
endpackage

// File: rtl/pkfifo_packer.sv
module pkfifo_packer #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              pack_en,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              word_req,
   output logic [WORD_W-1:0] word_out
);
   logic [BYTE_W-1:0] lo_q;
   logic              half_q;

   // A word is complete on every unpacked byte, or on the second packed byte.
   always_comb begin
      word_req = byte_vld && (!pack_en || half_q);
      if (pack_en) word_out = {byte_in, lo_q};
      else         word_out = {{BYTE_W{1'b0}}, byte_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         half_q <= 1'b0;
      end else if (init) begin
         half_q <= 1'b0;
      end else if (byte_vld) begin
         if (pack_en && !half_q) begin
            lo_q   <= byte_in;
            half_q <= 1'b1;
         end else begin
            half_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pkfifo_store.sv
module pkfifo_store #(
   parameter int unsigned DEPTH   = 1024,
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned SLICE_W = 4,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned NSLICE = WORD_W / SLICE_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   if (WORD_W % SLICE_W != 0) begin : g_bad_slice
      $error("pkfifo_store: WORD_W must be a multiple of SLICE_W");
   end

   // One narrow synchronous RAM per slice, all sharing address and strobes.
   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      logic [SLICE_W-1:0] mem [DEPTH];
      logic [SLICE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata[s*SLICE_W +: SLICE_W];
         if (re) rd_q <= mem[raddr];
      end

      assign rdata[s*SLICE_W +: SLICE_W] = rd_q;
   end
endmodule

// File: rtl/pkfifo_ctrl.sv
module pkfifo_ctrl
   import pkfifo_pkg::*;
#(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              err_clr,
   input  logic              word_req,
   input  logic [WORD_W-1:0] word_in,
   input  logic              rd_strobe,
   output logic              ram_we,
   output logic [AW-1:0]     ram_waddr,
   output logic [WORD_W-1:0] ram_wdata,
   output logic              ram_re,
   output logic [AW-1:0]     ram_raddr,
   output logic              rd_valid,
   output logic [CW-1:0]     word_count,
   output logic              empty,
   output logic              full,
   output logic              overflow,
   output logic              underflow
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("pkfifo_ctrl: DEPTH must be a power of two");
   end

   slot_e             slot_q;
   logic              wq_q, rq_q, rvld_q, ovf_q, unf_q;
   logic [WORD_W-1:0] wq_word_q;
   logic [AW-1:0]     wptr_q, rptr_q;
   logic [CW-1:0]     cnt_q;

   logic commit, service, at_limit, wr_take, wr_reject, rd_take, rd_reject;

   always_comb begin
      commit    = wq_q && (slot_q == SLOT_WR);
      service   = rq_q && (slot_q == SLOT_RD);
      // A pending write counts against capacity before it reaches the array.
      at_limit  = (cnt_q + CW'(wq_q)) == CW'(DEPTH);
      wr_take   = word_req && !at_limit;
      wr_reject = word_req && at_limit;
      rd_take   = rd_strobe && (cnt_q != '0);
      rd_reject = rd_strobe && (cnt_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q    <= SLOT_WR;
         wq_q      <= 1'b0;
         rq_q      <= 1'b0;
         rvld_q    <= 1'b0;
         ovf_q     <= 1'b0;
         unf_q     <= 1'b0;
         wq_word_q <= '0;
         wptr_q    <= '0;
         rptr_q    <= '0;
         cnt_q     <= '0;
      end else if (init) begin
         slot_q <= SLOT_WR;
         wq_q   <= 1'b0;
         rq_q   <= 1'b0;
         rvld_q <= 1'b0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         slot_q <= (slot_q == SLOT_WR) ? SLOT_RD : SLOT_WR;

         if (wr_take) begin
            wq_q      <= 1'b1;
            wq_word_q <= word_in;
         end else if (commit) begin
            wq_q <= 1'b0;
         end
         if (commit) wptr_q <= wptr_q + 1'b1;

         if (rd_take)      rq_q <= 1'b1;
         else if (service) rq_q <= 1'b0;
         if (service) rptr_q <= rptr_q + 1'b1;
         rvld_q <= service;

         cnt_q <= cnt_q + CW'(commit) - CW'(rd_take);

         if (wr_reject)    ovf_q <= 1'b1;
         else if (err_clr) ovf_q <= 1'b0;
         if (rd_reject)    unf_q <= 1'b1;
         else if (err_clr) unf_q <= 1'b0;
      end
   end

   assign ram_we     = commit;
   assign ram_waddr  = wptr_q;
   assign ram_wdata  = wq_word_q;
   assign ram_re     = service;
   assign ram_raddr  = rptr_q;
   assign rd_valid   = rvld_q;
   assign word_count = cnt_q;
   assign empty      = (cnt_q == '0);
   assign full       = (cnt_q == CW'(DEPTH));
   assign overflow   = ovf_q;
   assign underflow  = unf_q;
endmodule

// File: rtl/pkfifo.sv
module pkfifo #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned DEPTH   = 1024,
   parameter int unsigned SLICE_W = 4,
   localparam int unsigned WORD_W = 2 * BYTE_W,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              err_clr,
   input  logic              pack_en,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              rd_strobe,
   output logic [WORD_W-1:0] rd_word,
   output logic              rd_valid,
   output logic [CW-1:0]     word_count,
   output logic              empty,
   output logic              full,
   output logic              overflow,
   output logic              underflow
);
   if (BYTE_W < 1 || DEPTH < 2) begin : g_bad_cfg
      $error("pkfifo: BYTE_W and DEPTH out of range");
   end

   logic              word_req;
   logic [WORD_W-1:0] word_new;
   logic              ram_we, ram_re;
   logic [AW-1:0]     ram_waddr, ram_raddr;
   logic [WORD_W-1:0] ram_wdata;

   pkfifo_packer #(.BYTE_W(BYTE_W)) packer_i (
      .clk(clk), .rst_n(rst_n), .init(init), .pack_en(pack_en),
      .byte_vld(byte_vld), .byte_in(byte_in),
      .word_req(word_req), .word_out(word_new)
   );

   pkfifo_ctrl #(.DEPTH(DEPTH), .WORD_W(WORD_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .init(init), .err_clr(err_clr),
      .word_req(word_req), .word_in(word_new), .rd_strobe(rd_strobe),
      .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
      .ram_re(ram_re), .ram_raddr(ram_raddr), .rd_valid(rd_valid),
      .word_count(word_count), .empty(empty), .full(full),
      .overflow(overflow), .underflow(underflow)
   );

   pkfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .SLICE_W(SLICE_W)) store_i (
      .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
      .re(ram_re), .raddr(ram_raddr), .rdata(rd_word)
   );
endmodule

// File: rtl/pkfifo_chk.sv
module pkfifo_chk #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          init,
   input logic          err_clr,
   input logic          rd_strobe,
   input logic          empty,
   input logic          full,
   input logic          overflow,
   input logic          underflow,
   input logic [CW-1:0] word_count,
   input logic          ram_we,
   input logic          ram_re
);
   assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      word_count <= CW'(DEPTH));

   assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   assert_underflow_on_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && empty && !init) |=> underflow);

   assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !err_clr && !init) |=> overflow);

   assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !err_clr && !init) |=> underflow);

   assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !init |=> (word_count == $past(word_count)) ||
                (word_count == $past(word_count) + CW'(1)) ||
                (word_count == $past(word_count) - CW'(1)));
endmodule

bind pkfifo pkfifo_chk #(.DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .init(init), .err_clr(err_clr),
   .rd_strobe(rd_strobe), .empty(empty), .full(full),
   .overflow(overflow), .underflow(underflow), .word_count(word_count),
   .ram_we(ram_we), .ram_re(ram_re)
);

// File: tb/pkfifo_tb_top.sv
module pkfifo_tb_top;
   localparam int unsigned DEPTH = 1024;

   logic        clk = 1'b0;
   logic        rst_n, init, err_clr, pack_en, byte_vld, rd_strobe;
   logic [7:0]  byte_in;
   logic [15:0] rd_word;
   logic        rd_valid, empty, full, overflow, underflow;
   logic [10:0] word_count;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] exp_q [2048];
   int head = 0;
   int tail = 0;

   always #5 clk = ~clk;

   pkfifo #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .init(init), .err_clr(err_clr),
      .pack_en(pack_en), .byte_vld(byte_vld), .byte_in(byte_in),
      .rd_strobe(rd_strobe), .rd_word(rd_word), .rd_valid(rd_valid),
      .word_count(word_count), .empty(empty), .full(full),
      .overflow(overflow), .underflow(underflow)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_byte(input logic [7:0] b);
      byte_vld = 1'b1;
      byte_in  = b;
      @(negedge clk);
      byte_vld = 1'b0;
      @(negedge clk);
   endtask

   task automatic put_word(input logic [15:0] w);
      put_byte(w[7:0]);
      put_byte(w[15:8]);
      exp_q[tail % 2048] = w;
      tail++;
   endtask

   task automatic get_word(output logic [15:0] w, output bit got);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      got = 1'b0;
      w = '0;
      repeat (4) begin
         @(negedge clk);
         if (!got && rd_valid) begin
            got = 1'b1;
            w = rd_word;
         end
      end
   endtask

   task automatic pop_check(input string tag);
      logic [15:0] w;
      bit got;
      get_word(w, got);
      chk(got, {tag, " rd_valid"}, 32'(got), 32'd1);
      chk(w == exp_q[head % 2048], {tag, " data"}, 32'(w), 32'(exp_q[head % 2048]));
      head++;
   endtask

   function automatic logic [15:0] fill_pat(input int i);
      logic [9:0] k = 10'(i);
      return {k[9:2] ^ 8'hC3, k[7:0]};
   endfunction

   task automatic t_reset_R1;
      chk(empty == 1'b1, "R1 empty", 32'(empty), 32'd1);
      chk(full == 1'b0, "R1 full", 32'(full), 32'd0);
      chk(overflow == 1'b0 && underflow == 1'b0, "R1 errors",
          32'({overflow, underflow}), 32'd0);
      chk(word_count == 0, "R1 count", 32'(word_count), 32'd0);
      chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);
   endtask

   task automatic t_packed_R2;
      pack_en = 1'b1;
      put_byte(8'h34);
      idle(3);
      chk(word_count == 0, "R2 count after first byte", 32'(word_count), 32'd0);
      put_byte(8'h12);
      idle(3);
      chk(word_count == 1, "R2 count after second byte", 32'(word_count), 32'd1);
      exp_q[tail % 2048] = 16'h1234;
      tail++;
      pop_check("R2 packed order");
   endtask

   task automatic t_unpacked_R3;
      pack_en = 1'b0;
      put_byte(8'hA5);
      idle(3);
      chk(word_count == 1, "R3 count", 32'(word_count), 32'd1);
      exp_q[tail % 2048] = 16'h00A5;
      tail++;
      put_byte(8'hFF);
      exp_q[tail % 2048] = 16'h00FF;
      tail++;
      pop_check("R3 zero extend");
      pop_check("R3 zero extend second");
      pack_en = 1'b1;
   endtask

   task automatic t_order_R4;
      put_word(16'hBEEF);
      put_word(16'h0001);
      put_word(16'h8000);
      idle(3);
      chk(word_count == 3, "R10 count three", 32'(word_count), 32'd3);
      pop_check("R4 order 0");
      pop_check("R4 order 1");
      pop_check("R4 order 2");
      chk(empty == 1'b1, "R4 empty after drain", 32'(empty), 32'd1);
   endtask

   task automatic t_underflow_R6;
      logic [15:0] w;
      bit got;
      get_word(w, got);
      chk(!got, "R6 no rd_valid", 32'(got), 32'd0);
      chk(underflow == 1'b1, "R6 underflow set", 32'(underflow), 32'd1);
      chk(word_count == 0, "R6 count", 32'(word_count), 32'd0);
      idle(5);
      chk(underflow == 1'b1, "R7 underflow sticky", 32'(underflow), 32'd1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk(underflow == 1'b0, "R7 underflow cleared", 32'(underflow), 32'd0);
   endtask

   task automatic t_fill_R5;
      for (int i = 0; i < int'(DEPTH); i++) put_word(fill_pat(i));
      idle(3);
      chk(full == 1'b1, "R5 full", 32'(full), 32'd1);
      chk(word_count == 11'(DEPTH), "R10 count at limit", 32'(word_count), DEPTH);
      chk(overflow == 1'b0, "R5 no early overflow", 32'(overflow), 32'd0);
      put_byte(8'h11);
      put_byte(8'h22);
      idle(3);
      chk(overflow == 1'b1, "R5 overflow set", 32'(overflow), 32'd1);
      chk(word_count == 11'(DEPTH), "R5 count unchanged", 32'(word_count), DEPTH);
      idle(4);
      chk(overflow == 1'b1, "R7 overflow sticky", 32'(overflow), 32'd1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk(overflow == 1'b0, "R7 overflow cleared", 32'(overflow), 32'd0);
      for (int i = 0; i < int'(DEPTH); i++) pop_check("R5 drain contents");
      chk(empty == 1'b1 && word_count == 0, "R5 empty after drain",
          32'(word_count), 32'd0);
   endtask

   task automatic t_init_R8;
      put_word(16'h1111);
      put_word(16'h2222);
      put_byte(8'h77);
      init = 1'b1;
      @(negedge clk);
      init = 1'b0;
      head = tail;
      chk(empty == 1'b1 && word_count == 0, "R8 cleared", 32'(word_count), 32'd0);
      put_word(16'h5A3C);
      idle(3);
      chk(word_count == 1, "R8 held byte dropped", 32'(word_count), 32'd1);
      pop_check("R8 new data first");
   endtask

   task automatic t_mixed_R9;
      for (int i = 0; i < 4; i++) put_word(16'hC000 + 16'(i));
      for (int k = 0; k < 20; k++) begin
         put_word(16'h7100 + 16'(k));
         pop_check("R9 interleaved stream");
      end
      for (int i = 0; i < 4; i++) pop_check("R9 interleaved tail");
      idle(3);
      chk(word_count == 0, "R10 count after mix", 32'(word_count), 32'd0);
   endtask

   initial begin
      rst_n = 1'b0; init = 1'b0; err_clr = 1'b0; pack_en = 1'b1;
      byte_vld = 1'b0; byte_in = '0; rd_strobe = 1'b0;
      idle(4);
      rst_n = 1'b1;
      idle(2);
      t_reset_R1();
      t_packed_R2();
      t_unpacked_R3();
      t_order_R4();
      t_underflow_R6();
      t_fill_R5();
      t_init_R8();
      t_mixed_R9();
      idle(4);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule